// File: doc/BRIEF.md
# SPI Display Command Framer

This block turns high-level requests from a drawing engine into the byte framing that a small TFT panel controller expects on its serial port. It drives chip select and an 8-bit SPI master in mode 3 (clock idles high, data changes on the falling edge and is sampled on the rising edge, most significant bit first). Every transfer under one chip-select assertion begins with a start byte: 0x70 marks an index phase that selects a controller register, and 0x72 marks a data phase.

Four kinds of request exist. A register write is an index frame followed by a data frame. A bare index frame selects a register and sends no value. A drawing-window setup expands into a fixed run of register writes that set the horizontal and vertical limits and the start address, then opens the memory-write port. A pixel stream sends one data start byte and then an unbroken run of 16-bit pixels accepted through a valid/ready handshake.

Chip select is held high for a guard time between frames. The guard time is a cycle count derived from the clock frequency and a nanosecond parameter; the serial clock half period is a separate parameter.

Top module: `spi_cmd_framer`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 1, busy is 0 and pix_ready is 0.
- R2: A request with req_kind 1 sends one frame: chip select low, byte 0x70, req_reg[15:8], req_reg[7:0], chip select high; every byte goes out most significant bit first.
- R3: A request with req_kind 0 sends an index frame for req_reg, then a second frame of 0x72, req_value[15:8], req_value[7:0].
- R4: Between two frames, spi_cs_n stays high for at least GAP_CYC = ceil(CLK_HZ * GAP_NS / 1e9) clock cycles.
- R5: A request with req_kind 2 sends seven frames in this order: register 0x0044 written with {left+width-1, left}, register 0x0045 written with {top+height-1, top}, register 0x0021 written with {top, left}, then a bare index frame for register 0x0022; each edge is 8 bits and wraps modulo 256.
- R6: A request with req_kind 3 and req_no_pix 0 keeps chip select low for one frame: byte 0x72 once, then each accepted pixel high byte first; chip select rises only after the pixel that carried pix_last.
- R7: A request with req_kind 3 and req_no_pix 1 sends a frame holding only 0x72 and then raises chip select.
- R8: busy rises on the cycle after a request is accepted and falls on the same edge on which the final chip-select rise occurs; req_valid while busy is 1 has no effect.
- R9: spi_sclk is high whenever spi_cs_n is high, and pix_ready is 1 only while a pixel stream is waiting for its next pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_kind | input | 2 | 0 register write, 1 index only, 2 window setup, 3 pixel stream |
| req_reg | input | 16 | Register address for kinds 0 and 1 |
| req_value | input | 16 | Register value for kind 0 |
| req_left | input | 8 | Window left column |
| req_top | input | 8 | Window top row |
| req_width | input | 8 | Window width in pixels |
| req_height | input | 8 | Window height in pixels |
| req_no_pix | input | 1 | Pixel stream carries no pixels |
| busy | output | 1 | Request in progress |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | 16 | Pixel value |
| pix_last | input | 1 | Offered pixel is the final one |
| pix_ready | output | 1 | Pixel accepted on this edge when valid |
| spi_cs_n | output | 1 | Panel chip select, active low |
| spi_sclk | output | 1 | Serial clock, mode 3 |
| spi_mosi | output | 1 | Serial data to panel |

## Verification
The bench decodes the serial pins itself and compares whole frames against a model of the request, so a window setup that swapped the end and start bytes, left out the trailing bare index frame for register 0x0022, or computed the end edge without the minus one would show a wrong byte in a named frame. A pixel stream with stalls between pixels catches a design that drops chip select between pixels or repeats the start byte, and the empty stream catches one that waits forever for a pixel. A request strobed in the middle of a register write would show up as extra frames if it were latched, and measured chip-select high times catch a guard time that is skipped or counted short.

// File: rtl/framer_pkg.sv
package framer_pkg;

    typedef enum logic [1:0] {
        K_REG = 2'd0,
        K_IDX = 2'd1,
        K_WIN = 2'd2,
        K_PIX = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_GAP,
        S_BYTE,
        S_PIXW
    } seq_state_e;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int COORD_W = BYTE_W;

    localparam logic [BYTE_W-1:0] LEAD_INDEX = 8'h70;
    localparam logic [BYTE_W-1:0] LEAD_DATA  = 8'h72;

    localparam logic [WORD_W-1:0] REG_HLIMIT = 16'h0044;
    localparam logic [WORD_W-1:0] REG_VLIMIT = 16'h0045;
    localparam logic [WORD_W-1:0] REG_CURSOR = 16'h0021;
    localparam logic [WORD_W-1:0] REG_MEMWR  = 16'h0022;

    typedef struct packed {
        logic              is_data;
        logic [WORD_W-1:0] word;
    } frame_t;

endpackage

// File: rtl/frame_map.sv
module frame_map
    import framer_pkg::*;
(
    input  req_kind_e          kind,
    input  logic [2:0]         frame_idx,
    input  logic [WORD_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_val,
    input  logic [COORD_W-1:0] left,
    input  logic [COORD_W-1:0] top,
    input  logic [COORD_W-1:0] width,
    input  logic [COORD_W-1:0] height,
    output frame_t             frm,
    output logic [2:0]         frame_count
);
    logic [COORD_W-1:0] h_end;
    logic [COORD_W-1:0] v_end;

    always_comb begin
        h_end = left + width - COORD_W'(1);
        v_end = top + height - COORD_W'(1);
        frm   = '{is_data: 1'b0, word: '0};
        frame_count = 3'd1;
        unique case (kind)
            K_REG: begin
                frame_count = 3'd2;
                if (frame_idx == 3'd0) frm = '{is_data: 1'b0, word: reg_addr};
                else                   frm = '{is_data: 1'b1, word: reg_val};
            end
            K_IDX: begin
                frame_count = 3'd1;
                frm = '{is_data: 1'b0, word: reg_addr};
            end
            K_WIN: begin
                frame_count = 3'd7;
                case (frame_idx)
                    3'd0:    frm = '{is_data: 1'b0, word: REG_HLIMIT};
                    3'd1:    frm = '{is_data: 1'b1, word: {h_end, left}};
                    3'd2:    frm = '{is_data: 1'b0, word: REG_VLIMIT};
                    3'd3:    frm = '{is_data: 1'b1, word: {v_end, top}};
                    3'd4:    frm = '{is_data: 1'b0, word: REG_CURSOR};
                    3'd5:    frm = '{is_data: 1'b1, word: {top, left}};
                    default: frm = '{is_data: 1'b0, word: REG_MEMWR};
                endcase
            end
            default: begin
                frame_count = 3'd1;
                frm = '{is_data: 1'b1, word: '0};
            end
        endcase
    end
endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx
    import framer_pkg::*;
#(
    parameter int HALF_CYC = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              tx_busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam int BW = $clog2(BYTE_W);

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              mosi;
        logic [BYTE_W-1:0] shreg;
        logic [BW-1:0]     bitn;
        logic [CW-1:0]     cnt;
        logic              done;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        tx_d.done = 1'b0;
        if (!tx_q.busy) begin
            if (start) begin
                tx_d.busy  = 1'b1;
                tx_d.sclk  = 1'b0;
                tx_d.mosi  = byte_in[BYTE_W-1];
                tx_d.shreg = {byte_in[BYTE_W-2:0], 1'b0};
                tx_d.bitn  = '0;
                tx_d.cnt   = '0;
            end
        end else if (tx_q.cnt == CW'(HALF_CYC - 1)) begin
            tx_d.cnt = '0;
            if (!tx_q.sclk) begin
                tx_d.sclk = 1'b1;
            end else if (tx_q.bitn == BW'(BYTE_W - 1)) begin
                tx_d.busy = 1'b0;
                tx_d.done = 1'b1;
            end else begin
                tx_d.sclk  = 1'b0;
                tx_d.mosi  = tx_q.shreg[BYTE_W-1];
                tx_d.shreg = {tx_q.shreg[BYTE_W-2:0], 1'b0};
                tx_d.bitn  = tx_q.bitn + BW'(1);
            end
        end else begin
            tx_d.cnt = tx_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '{busy: 1'b0, sclk: 1'b1, mosi: 1'b0, shreg: '0,
                      bitn: '0, cnt: '0, done: 1'b0};
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_busy = tx_q.busy;
    assign done    = tx_q.done;
    assign sclk    = tx_q.sclk;
    assign mosi    = tx_q.mosi;

    // R2: a byte is never launched while the previous one is still shifting
    assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !tx_q.busy);

    // R9: the byte ends with the serial clock back at its idle level
    assert_done_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.done |-> tx_q.sclk);

    // R2: the clock level only moves while a byte is in flight
    assert_sclk_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_q.busy && !start) |=> $stable(tx_q.sclk));
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
    import framer_pkg::*;
#(
    parameter int CLK_HZ    = 200_000_000,
    parameter int GAP_NS    = 1000,
    parameter int SCLK_HALF = 17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [15:0] req_reg,
    input  logic [15:0] req_value,
    input  logic [7:0]  req_left,
    input  logic [7:0]  req_top,
    input  logic [7:0]  req_width,
    input  logic [7:0]  req_height,
    input  logic        req_no_pix,
    output logic        busy,
    input  logic        pix_valid,
    input  logic [15:0] pix_data,
    input  logic        pix_last,
    output logic        pix_ready,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi
);
    localparam longint GAP_L   = (longint'(CLK_HZ) * longint'(GAP_NS) + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int     GAP_CYC = int'(GAP_L);
    localparam int     GW      = $clog2(GAP_CYC + 2);

    typedef struct packed {
        seq_state_e         state;
        req_kind_e          kind;
        logic [WORD_W-1:0]  reg_addr;
        logic [WORD_W-1:0]  reg_val;
        logic [COORD_W-1:0] left;
        logic [COORD_W-1:0] top;
        logic [COORD_W-1:0] width;
        logic [COORD_W-1:0] height;
        logic               no_pix;
        logic [2:0]         frame;
        logic [1:0]         bidx;
        logic [WORD_W-1:0]  pix_word;
        logic               pix_end;
        logic               cs_n;
        logic               busy;
        logic [GW-1:0]      gcnt;
    } seq_t;

    seq_t s_d, s_q;

    logic              tx_start;
    logic [BYTE_W-1:0] tx_byte;
    logic              tx_busy;
    logic              tx_done;
    frame_t            cur_frm;
    logic [2:0]        frame_count;
    logic              finish;

    frame_map u_map (
        .kind        (s_q.kind),
        .frame_idx   (s_q.frame),
        .reg_addr    (s_q.reg_addr),
        .reg_val     (s_q.reg_val),
        .left        (s_q.left),
        .top         (s_q.top),
        .width       (s_q.width),
        .height      (s_q.height),
        .frm         (cur_frm),
        .frame_count (frame_count)
    );

    spi_byte_tx #(.HALF_CYC(SCLK_HALF)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .byte_in (tx_byte),
        .tx_busy (tx_busy),
        .done    (tx_done),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    always_comb begin
        s_d      = s_q;
        tx_start = 1'b0;
        tx_byte  = '0;
        finish   = 1'b0;

        if (s_q.cs_n && (s_q.gcnt < GW'(GAP_CYC))) s_d.gcnt = s_q.gcnt + GW'(1);

        unique case (s_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    s_d.state    = S_GAP;
                    s_d.kind     = req_kind_e'(req_kind);
                    s_d.reg_addr = req_reg;
                    s_d.reg_val  = req_value;
                    s_d.left     = req_left;
                    s_d.top      = req_top;
                    s_d.width    = req_width;
                    s_d.height   = req_height;
                    s_d.no_pix   = req_no_pix;
                    s_d.frame    = '0;
                    s_d.busy     = 1'b1;
                end
            end
            S_GAP: begin
                if (s_q.gcnt >= GW'(GAP_CYC)) begin
                    tx_start  = 1'b1;
                    tx_byte   = cur_frm.is_data ? LEAD_DATA : LEAD_INDEX;
                    s_d.cs_n  = 1'b0;
                    s_d.bidx  = 2'd0;
                    s_d.state = S_BYTE;
                end
            end
            S_BYTE: begin
                if (tx_done) begin
                    if (s_q.kind == K_PIX) begin
                        if (s_q.bidx == 2'd0) begin
                            if (s_q.no_pix) finish = 1'b1;
                            else            s_d.state = S_PIXW;
                        end else if (s_q.bidx == 2'd1) begin
                            tx_start = 1'b1;
                            tx_byte  = s_q.pix_word[BYTE_W-1:0];
                            s_d.bidx = 2'd2;
                        end else begin
                            if (s_q.pix_end) finish = 1'b1;
                            else             s_d.state = S_PIXW;
                        end
                    end else begin
                        if (s_q.bidx == 2'd0) begin
                            tx_start = 1'b1;
                            tx_byte  = cur_frm.word[WORD_W-1:BYTE_W];
                            s_d.bidx = 2'd1;
                        end else if (s_q.bidx == 2'd1) begin
                            tx_start = 1'b1;
                            tx_byte  = cur_frm.word[BYTE_W-1:0];
                            s_d.bidx = 2'd2;
                        end else begin
                            finish = 1'b1;
                        end
                    end
                end
            end
            S_PIXW: begin
                if (pix_valid) begin
                    tx_start     = 1'b1;
                    tx_byte      = pix_data[WORD_W-1:BYTE_W];
                    s_d.pix_word = pix_data;
                    s_d.pix_end  = pix_last;
                    s_d.bidx     = 2'd1;
                    s_d.state    = S_BYTE;
                end
            end
            default: s_d.state = S_IDLE;
        endcase

        if (finish) begin
            s_d.cs_n = 1'b1;
            s_d.gcnt = '0;
            if ((s_q.frame + 3'd1) < frame_count) begin
                s_d.frame = s_q.frame + 3'd1;
                s_d.state = S_GAP;
            end else begin
                s_d.busy  = 1'b0;
                s_d.state = S_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: S_IDLE, kind: K_REG, reg_addr: '0, reg_val: '0,
                     left: '0, top: '0, width: '0, height: '0, no_pix: 1'b0,
                     frame: '0, bidx: '0, pix_word: '0, pix_end: 1'b0,
                     cs_n: 1'b1, busy: 1'b0, gcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign spi_cs_n  = s_q.cs_n;
    assign pix_ready = (s_q.state == S_PIXW);

    // R4: chip select only falls after the guard counter has run out
    assert_gap_met_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.cs_n) |-> ($past(s_q.gcnt) >= GW'(GAP_CYC)));

    // R8: chip select is never low outside a request
    assert_cs_inside_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cs_n |-> s_q.busy);

    // R8: busy only rises from an offered request
    assert_busy_from_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> $past(req_valid));

    // R9: the serial clock idles high while chip select is high
    assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cs_n |-> spi_sclk);

    // R6: pixels are only taken inside an open frame with the shifter idle
    assert_ready_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> (!s_q.cs_n && !tx_busy));

    // R8: a request offered while busy leaves the latched request unchanged
    assert_busy_ignores_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.state != S_IDLE) |=> ($stable(s_q.kind) && $stable(s_q.reg_addr)));
endmodule

// File: tb/tb_spi_cmd_framer.sv
module tb_spi_cmd_framer;
    localparam int CLK_HZ    = 200_000_000;
    localparam int GAP_NS    = 100;
    localparam int SCLK_HALF = 2;
    localparam int GAP_CYC   = 20;   // ceil(200e6 * 100e-9)

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] reg_a;
        logic [15:0] val;
        logic [7:0]  l;
        logic [7:0]  t;
        logic [7:0]  w;
        logic [7:0]  h;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 16'h0007, 16'h0037, 8'd0,   8'd0,   8'd0,   8'd0},
        '{2'd0, 16'h0013, 16'h081E, 8'd0,   8'd0,   8'd0,   8'd0},
        '{2'd1, 16'h0022, 16'h0000, 8'd0,   8'd0,   8'd0,   8'd0},
        '{2'd2, 16'h0000, 16'h0000, 8'd0,   8'd0,   8'd128, 8'd160},
        '{2'd2, 16'h0000, 16'h0000, 8'd10,  8'd20,  8'd1,   8'd1},
        '{2'd2, 16'h0000, 16'h0000, 8'd250, 8'd5,   8'd10,  8'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [15:0] req_reg = '0, req_value = '0;
    logic [7:0] req_left = '0, req_top = '0, req_width = '0, req_height = '0;
    logic req_no_pix = 1'b0;
    logic busy;
    logic pix_valid = 1'b0;
    logic [15:0] pix_data = '0;
    logic pix_last = 1'b0;
    logic pix_ready, spi_cs_n, spi_sclk, spi_mosi;

    always #2.5 clk = ~clk;

    spi_cmd_framer #(.CLK_HZ(CLK_HZ), .GAP_NS(GAP_NS), .SCLK_HALF(SCLK_HALF)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_reg(req_reg), .req_value(req_value), .req_left(req_left),
        .req_top(req_top), .req_width(req_width), .req_height(req_height),
        .req_no_pix(req_no_pix), .busy(busy), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_last(pix_last), .pix_ready(pix_ready),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // serial monitor
    logic [7:0] log_b [0:4095];
    int flen [0:511];
    int fgap [0:511];
    int log_nb = 0, log_nf = 0, cur_len = 0, nbit = 0, hi_cnt = 0;
    int idle_bad = 0, partial = 0;
    logic [7:0] sh = '0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n && !spi_sclk) idle_bad++;
            if (!spi_cs_n && prev_cs) fgap[log_nf] = hi_cnt;
            if (spi_cs_n) hi_cnt++; else hi_cnt = 0;
            if (!spi_cs_n && spi_sclk && !prev_sclk) begin
                sh = {sh[6:0], spi_mosi};
                nbit++;
                if (nbit == 8) begin
                    log_b[log_nb] = sh;
                    log_nb++;
                    cur_len++;
                    nbit = 0;
                end
            end
            if (spi_cs_n && !prev_cs) begin
                flen[log_nf] = cur_len;
                log_nf++;
                cur_len = 0;
                if (nbit != 0) partial++;
                nbit = 0;
            end
            prev_cs   = spi_cs_n;
            prev_sclk = spi_sclk;
        end
    end

    // expected frames
    logic [7:0] exp_b [0:1023];
    int exp_len [0:63];
    int exp_nb = 0, exp_nf = 0;

    task automatic exp_clear();
        exp_nb = 0;
        exp_nf = 0;
    endtask

    task automatic exp_frame(input bit is_data, input logic [15:0] w);
        exp_b[exp_nb]   = is_data ? 8'h72 : 8'h70;
        exp_b[exp_nb+1] = w[15:8];
        exp_b[exp_nb+2] = w[7:0];
        exp_nb += 3;
        exp_len[exp_nf] = 3;
        exp_nf++;
    endtask

    task automatic model(input vec_t v);
        logic [7:0] he, ve;
        he = v.l + v.w - 8'd1;
        ve = v.t + v.h - 8'd1;
        exp_clear();
        case (v.kind)
            2'd0: begin exp_frame(0, v.reg_a); exp_frame(1, v.val); end
            2'd1: exp_frame(0, v.reg_a);
            default: begin
                exp_frame(0, 16'h0044); exp_frame(1, {he, v.l});
                exp_frame(0, 16'h0045); exp_frame(1, {ve, v.t});
                exp_frame(0, 16'h0021); exp_frame(1, {v.t, v.l});
                exp_frame(0, 16'h0022);
            end
        endcase
    endtask

    task automatic compare(input string req, input int b0, input int f0);
        int bi, ei;
        check(log_nf - f0 == exp_nf, req, "frame count", log_nf - f0, exp_nf);
        if (log_nf - f0 == exp_nf) begin
            bi = b0;
            ei = 0;
            for (int f = 0; f < exp_nf; f++) begin
                bit ok;
                int a, e;
                ok = (flen[f0+f] == exp_len[f]);
                a = flen[f0+f];
                e = exp_len[f];
                if (ok) begin
                    for (int k = 0; k < exp_len[f]; k++) begin
                        if (ok && log_b[bi+k] != exp_b[ei+k]) begin
                            ok = 1'b0;
                            a = log_b[bi+k];
                            e = exp_b[ei+k];
                        end
                    end
                end
                check(ok, req, $sformatf("frame %0d", f), a, e);
                bi += flen[f0+f];
                ei += exp_len[f];
            end
            for (int f = 1; f < exp_nf; f++)
                check(fgap[f0+f] >= GAP_CYC, "R4", $sformatf("gap before frame %0d", f),
                      fgap[f0+f], GAP_CYC);
        end
    endtask

    task automatic issue(input vec_t v, input bit nopix);
        req_kind = v.kind; req_reg = v.reg_a; req_value = v.val;
        req_left = v.l; req_top = v.t; req_width = v.w; req_height = v.h;
        req_no_pix = nopix;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R8", "busy after accept", busy, 1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_pix(input logic [15:0] d, input bit last, input int stall);
        pix_data  = d;
        pix_last  = last;
        pix_valid = 1'b1;
        forever begin
            if (pix_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        pix_valid = 1'b0;
        repeat (stall) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int b0, f0;
        vec_t pv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 1'b1, "R1", "cs_n", spi_cs_n, 1);
        check(spi_sclk == 1'b1, "R1", "sclk", spi_sclk, 1);
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(pix_ready == 1'b0, "R1", "pix_ready", pix_ready, 0);

        // table walk: R2 index, R3 register write, R5 window
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = (VECS[i].kind == 2'd0) ? "R3" : (VECS[i].kind == 2'd1) ? "R2" : "R5";
            b0 = log_nb; f0 = log_nf;
            model(VECS[i]);
            issue(VECS[i], 1'b0);
            wait_idle();
            compare(tag, b0, f0);
        end

        // R8: request offered while busy is ignored; R9 pix_ready low during register write
        pv = '{2'd0, 16'h0044, 16'h1234, 8'd0, 8'd0, 8'd0, 8'd0};
        b0 = log_nb; f0 = log_nf;
        model(pv);
        issue(pv, 1'b0);
        repeat (30) @(negedge clk);
        check(pix_ready == 1'b0, "R9", "pix_ready in register write", pix_ready, 0);
        req_kind = 2'd1; req_reg = 16'h00AA; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        compare("R8", b0, f0);
        repeat (100) @(negedge clk);
        check(log_nf == f0 + 2, "R8", "no late frame", log_nf - f0, 2);
        check(busy == 1'b0, "R8", "idle after ignored request", busy, 0);

        // R6: pixel stream with stalls
        pv = '{2'd3, 16'h0, 16'h0, 8'd0, 8'd0, 8'd0, 8'd0};
        b0 = log_nb; f0 = log_nf;
        exp_clear();
        exp_b[0] = 8'h72;
        exp_b[1] = 8'hF8; exp_b[2] = 8'h00;
        exp_b[3] = 8'h07; exp_b[4] = 8'hE0;
        exp_b[5] = 8'hA5; exp_b[6] = 8'h5A;
        exp_b[7] = 8'h00; exp_b[8] = 8'h1F;
        exp_len[0] = 9; exp_nf = 1;
        issue(pv, 1'b0);
        send_pix(16'hF800, 1'b0, 0);
        send_pix(16'h07E0, 1'b0, 25);
        check(spi_cs_n == 1'b0, "R6", "cs held low during stall", spi_cs_n, 0);
        send_pix(16'hA55A, 1'b0, 3);
        send_pix(16'h001F, 1'b1, 0);
        wait_idle();
        compare("R6", b0, f0);
        check(pix_ready == 1'b0, "R9", "pix_ready after stream", pix_ready, 0);

        // R7: empty stream
        b0 = log_nb; f0 = log_nf;
        exp_clear();
        exp_b[0] = 8'h72; exp_len[0] = 1; exp_nf = 1;
        issue(pv, 1'b1);
        wait_idle();
        compare("R7", b0, f0);

        // R6: single-pixel stream
        b0 = log_nb; f0 = log_nf;
        exp_clear();
        exp_b[0] = 8'h72; exp_b[1] = 8'h12; exp_b[2] = 8'h34;
        exp_len[0] = 3; exp_nf = 1;
        issue(pv, 1'b0);
        send_pix(16'h1234, 1'b1, 0);
        wait_idle();
        compare("R6", b0, f0);

        // R9: clock idle level and whole bytes only
        check(idle_bad == 0, "R9", "sclk low while cs high", idle_bad, 0);
        check(partial == 0, "R2", "partial byte at frame end", partial, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule